// File: doc/BRIEF.md
# Nonvolatile Mode Sequence Detector

This block sits beside a parallel SRAM-style memory port and watches the host's bus cycles. A cycle is counted when chip enable returns high. Six such read cycles, with their addresses in one fixed order, unlock a nonvolatile operation. The sixth address selects either a save of the array into the nonvolatile cells or a reload from them. The block answers with a one-cycle command pulse to the array model. It then holds a busy indication until the array reports completion.

The block also remembers whether any SRAM write has happened since the last nonvolatile operation. An active-low hardware save request starts a save only when that flag is set. Either way, once the request has been handled the block enters standby and blocks all bus activity until the request pin goes high again. A combinational decode of the current bus state and a data-drive enable for the host data bus complete the interface.

Top module: `nvmode_seq_ctrl`

## Requirements
- R1: After reset, nv_store, nv_recall, busy and standby are all 0. With mem_ce_n high, bus_mode is 0 and dq_drive is 0.
- R2: Six consecutive read cycles with addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 produce exactly one nv_store pulse. busy rises in the same cycle and stays high until arr_done.
- R3: The same five leading addresses followed by 0x0C63 produce exactly one nv_recall pulse and raise busy.
- R4: A cycle with mem_we_n low at any point while chip enable is low breaks the sequence, so the following addresses complete nothing.
- R5: Address bit 14 takes no part in the comparison: the sequence with bit 14 set on every cycle still completes.
- R6: A mismatching address returns the match count to zero. If that address equals the first entry (0x0E38), the count restarts at one, so a sequence restarted in this way completes.
- R7: mem_oe_n has no effect on recognition: the sequence completes with mem_oe_n held high.
- R8: While busy, bus cycles are ignored (a full sequence issues nothing) and dq_drive is 0.
- R9: With hw_store_n low and an SRAM write since the last nonvolatile operation, one nv_store pulse is issued. After arr_done, busy falls and standby holds until hw_store_n is high.
- R10: With hw_store_n low and no SRAM write since the last nonvolatile operation, no pulse is issued and standby rises directly.
- R11: A completed recall or save clears the written flag, so a later hardware request issues no pulse.
- R12: bus_mode encodes 0 = deselected (mem_ce_n high), 1 = read, 2 = write (chip enable low, write enable low, hw_store_n high), 3 = inhibited (busy, standby, or hw_store_n low). dq_drive is 1 only in read mode with mem_oe_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ce_n | input | 1 | Chip enable, active low |
| mem_we_n | input | 1 | Write enable, active low |
| mem_oe_n | input | 1 | Output enable, active low |
| mem_addr | input | 15 | Bus address |
| hw_store_n | input | 1 | Hardware save request, active low |
| arr_done | input | 1 | Array model finished the current operation |
| nv_store | output | 1 | One-cycle save command |
| nv_recall | output | 1 | One-cycle reload command |
| busy | output | 1 | Nonvolatile operation in progress |
| standby | output | 1 | Waiting for hw_store_n to return high |
| bus_mode | output | 2 | Decoded bus mode |
| dq_drive | output | 1 | Drive the host data bus |

## Verification
The checker watches a set of properties on every cycle. It confirms that each command pulse coincides with busy and follows an idle cycle. It also checks that busy persists until arr_done, that standby persists while hw_store_n is low, that an active or waiting block reports the inhibited mode, and that the data bus is never driven in that state. Whether a given address order unlocks anything can only be shown by the bench's scenarios. The same holds for the effect of bit 14 and output enable, the restart after a stray first address, and the link from write history to hardware save requests.

// File: rtl/nvmode_pkg.sv
package nvmode_pkg;
  localparam int ADDR_W  = 15;
  localparam int KEY_W   = 14;
  localparam int SEQ_LEN = 6;

  localparam logic [KEY_W-1:0] KEY_STORE  = 14'h0FC0;
  localparam logic [KEY_W-1:0] KEY_RECALL = 14'h0C63;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HOLD} ctrl_state_t;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0, MODE_READ = 2'd1, MODE_WRITE = 2'd2, MODE_INHIBIT = 2'd3
  } bus_mode_t;

  // common prefix of the unlock order; the last step picks the operation
  function automatic logic [KEY_W-1:0] unlock_key(input int idx);
    case (idx)
      0:       unlock_key = 14'h0E38;
      1:       unlock_key = 14'h31C7;
      2:       unlock_key = 14'h03E0;
      3:       unlock_key = 14'h3C1F;
      default: unlock_key = 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvmode_bus_sampler.sv
module nvmode_bus_sampler #(
  parameter int KEY_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             hw_store_n,
  input  logic [KEY_W-1:0] key_in,
  output logic             cyc_end,
  output logic             cyc_wr,
  output logic [KEY_W-1:0] cyc_key
);
  logic             ce_q;
  logic             wr_acc_q, wr_acc_d;
  logic [KEY_W-1:0] key_hold_q, key_hold_d;
  logic             end_d;

  always_comb begin
    wr_acc_d   = wr_acc_q;
    key_hold_d = key_hold_q;
    if (!ce_n) begin
      wr_acc_d   = (ce_q ? 1'b0 : wr_acc_q) | (~we_n & hw_store_n);
      key_hold_d = key_in;
    end
    end_d = ce_n & ~ce_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q       <= 1'b1;
      wr_acc_q   <= 1'b0;
      key_hold_q <= '0;
      cyc_end    <= 1'b0;
      cyc_wr     <= 1'b0;
      cyc_key    <= '0;
    end else begin
      ce_q       <= ce_n;
      wr_acc_q   <= wr_acc_d;
      key_hold_q <= key_hold_d;
      cyc_end    <= end_d;
      if (end_d) begin
        cyc_wr  <= wr_acc_q;
        cyc_key <= key_hold_q;
      end
    end
  end
endmodule

// File: rtl/nvmode_unlock_det.sv
module nvmode_unlock_det
  import nvmode_pkg::*;
#(
  parameter int KEY_W   = 14,
  parameter int SEQ_LEN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cyc_end,
  input  logic             cyc_wr,
  input  logic [KEY_W-1:0] cyc_key,
  output logic             store_req,
  output logic             recall_req
);
  localparam int PRE_LEN = SEQ_LEN - 1;
  localparam int CNT_W   = $clog2(SEQ_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_LEN);

  logic [PRE_LEN-1:0] hit;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               st_d, rc_d;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_hit
    assign hit[i] = (cyc_key == unlock_key(i));
  end

  always_comb begin
    cnt_d = cnt_q;
    st_d  = 1'b0;
    rc_d  = 1'b0;
    if (enable && cyc_end) begin
      if (cyc_wr) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        if (cyc_key == KEY_STORE) begin
          st_d  = 1'b1;
          cnt_d = '0;
        end else if (cyc_key == KEY_RECALL) begin
          rc_d  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = hit[0] ? CNT_W'(1) : '0;
        end
      end else if (hit[cnt_q]) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = hit[0] ? CNT_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      store_req  <= st_d;
      recall_req <= rc_d;
    end
  end
endmodule

// File: rtl/nvmode_op_ctrl.sv
module nvmode_op_ctrl
  import nvmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_store_n,
  input  logic store_req,
  input  logic recall_req,
  input  logic wr_evt,
  input  logic arr_done,
  output logic nv_store,
  output logic nv_recall,
  output logic busy,
  output logic standby,
  output logic idle
);
  ctrl_state_t state_q, state_d;
  logic        hw_op_q, hw_op_d;
  logic        dirty_q, dirty_d;
  logic        st_d, rc_d;

  always_comb begin
    state_d = state_q;
    hw_op_d = hw_op_q;
    dirty_d = dirty_q;
    st_d    = 1'b0;
    rc_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_evt) dirty_d = 1'b1;
        if (!hw_store_n) begin
          if (dirty_q) begin
            st_d    = 1'b1;
            hw_op_d = 1'b1;
            state_d = ST_BUSY;
          end else begin
            state_d = ST_HOLD;
          end
        end else if (store_req || recall_req) begin
          st_d    = store_req;
          rc_d    = ~store_req;
          hw_op_d = 1'b0;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (arr_done) begin
          dirty_d = 1'b0;
          state_d = hw_op_q ? ST_HOLD : ST_IDLE;
        end
      end
      default: begin
        if (hw_store_n) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hw_op_q   <= 1'b0;
      dirty_q   <= 1'b0;
      nv_store  <= 1'b0;
      nv_recall <= 1'b0;
    end else begin
      state_q   <= state_d;
      hw_op_q   <= hw_op_d;
      dirty_q   <= dirty_d;
      nv_store  <= st_d;
      nv_recall <= rc_d;
    end
  end

  assign busy    = (state_q == ST_BUSY);
  assign standby = (state_q == ST_HOLD);
  assign idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/nvmode_seq_ctrl.sv
module nvmode_seq_ctrl
  import nvmode_pkg::*;
#(
  parameter int ADDR_W  = nvmode_pkg::ADDR_W,
  parameter int KEY_W   = nvmode_pkg::KEY_W,
  parameter int SEQ_LEN = nvmode_pkg::SEQ_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ce_n,
  input  logic              mem_we_n,
  input  logic              mem_oe_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              hw_store_n,
  input  logic              arr_done,
  output logic              nv_store,
  output logic              nv_recall,
  output logic              busy,
  output logic              standby,
  output logic [1:0]        bus_mode,
  output logic              dq_drive
);
  logic             cyc_end, cyc_wr, store_req, recall_req, idle;
  logic [KEY_W-1:0] cyc_key;
  logic             unused_addr_hi;

  assign unused_addr_hi = ^mem_addr[ADDR_W-1:KEY_W];

  nvmode_bus_sampler #(.KEY_W(KEY_W)) sampler_i (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n),
    .hw_store_n(hw_store_n), .key_in(mem_addr[KEY_W-1:0]),
    .cyc_end(cyc_end), .cyc_wr(cyc_wr), .cyc_key(cyc_key)
  );

  nvmode_unlock_det #(.KEY_W(KEY_W), .SEQ_LEN(SEQ_LEN)) unlock_i (
    .clk(clk), .rst_n(rst_n), .enable(idle), .cyc_end(cyc_end),
    .cyc_wr(cyc_wr), .cyc_key(cyc_key),
    .store_req(store_req), .recall_req(recall_req)
  );

  nvmode_op_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .hw_store_n(hw_store_n),
    .store_req(store_req), .recall_req(recall_req),
    .wr_evt(cyc_end & cyc_wr), .arr_done(arr_done),
    .nv_store(nv_store), .nv_recall(nv_recall),
    .busy(busy), .standby(standby), .idle(idle)
  );

  always_comb begin
    if (!idle || !hw_store_n) bus_mode = MODE_INHIBIT;
    else if (mem_ce_n)        bus_mode = MODE_DESEL;
    else if (!mem_we_n)       bus_mode = MODE_WRITE;
    else                      bus_mode = MODE_READ;
  end

  assign dq_drive = (bus_mode == MODE_READ) && !mem_oe_n;
endmodule

// File: rtl/nvmode_seq_ctrl_chk.sv
module nvmode_seq_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hw_store_n,
  input logic              arr_done,
  input logic              nv_store,
  input logic              nv_recall,
  input logic              busy,
  input logic              standby,
  input logic [1:0]        bus_mode,
  input logic              dq_drive
);
  // R2/R3: every command pulse coincides with busy
  a_r2_pulse_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_store || nv_recall) |-> busy);

  // R2: a command is a single-cycle pulse
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_store || nv_recall) |=> !(nv_store || nv_recall));

  // R8: commands start only from an idle cycle
  a_r8_pulse_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_store || nv_recall) |-> $past(!busy && !standby));

  // R8: data bus never driven while busy or waiting
  a_r8_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || standby) |-> !dq_drive);

  // R9: busy persists until completion
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arr_done) |=> busy);

  // R9: standby persists while the request pin stays low
  a_r9_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !hw_store_n) |=> standby);

  // R12: inhibited mode reported while active or waiting
  a_r12_inhibit_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || standby) |-> (bus_mode == 2'd3));
endmodule

bind nvmode_seq_ctrl nvmode_seq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/nvmode_seq_ctrl_tb_top.sv
module nvmode_seq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int KIND_STORE = 1;
  localparam int KIND_RECALL = 2;

  logic        clk, rst_n;
  logic        mem_ce_n, mem_we_n, mem_oe_n, hw_store_n, arr_done;
  logic [14:0] mem_addr;
  logic        nv_store, nv_recall, busy, standby, dq_drive;
  logic [1:0]  bus_mode;

  int    checks, errors;
  bit    done_flag;
  string cur_req;
  int    exp_kind[$];
  string exp_req[$];

  nvmode_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .hw_store_n(hw_store_n),
    .arr_done(arr_done), .nv_store(nv_store), .nv_recall(nv_recall),
    .busy(busy), .standby(standby), .bus_mode(bus_mode), .dq_drive(dq_drive)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input int kind, input string req);
    exp_kind.push_back(kind);
    exp_req.push_back(req);
  endtask

  // monitor: compare each observed command against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (nv_store || nv_recall)) begin
      int k;
      k = nv_store ? KIND_STORE : KIND_RECALL;
      if (exp_kind.size() == 0) begin
        check(1'b0, cur_req, k, 0);
      end else begin
        int    e;
        string r;
        e = exp_kind.pop_front();
        r = exp_req.pop_front();
        check(k == e, r, k, e);
      end
    end
  end

  task automatic bus_cycle(input logic [14:0] a, input logic we, input logic oe);
    @(negedge clk);
    mem_ce_n = 1'b0; mem_addr = a; mem_we_n = we; mem_oe_n = oe;
    repeat (2) @(negedge clk);
    mem_ce_n = 1'b1; mem_we_n = 1'b1; mem_oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock_seq(input logic [14:0] last, input logic [14:0] hi, input logic oe);
    bus_cycle(15'h0E38 | hi, 1'b1, oe);
    bus_cycle(15'h31C7 | hi, 1'b1, oe);
    bus_cycle(15'h03E0 | hi, 1'b1, oe);
    bus_cycle(15'h3C1F | hi, 1'b1, oe);
    bus_cycle(15'h303F | hi, 1'b1, oe);
    bus_cycle(last | hi, 1'b1, oe);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_op;
    @(negedge clk); arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic queue_drained(input string req);
    check(exp_kind.size() == 0, req, exp_kind.size(), 0);
  endtask

  initial begin
    checks = 0; errors = 0; done_flag = 0; cur_req = "R1";
    rst_n = 1'b0; mem_ce_n = 1'b1; mem_we_n = 1'b1; mem_oe_n = 1'b1;
    mem_addr = '0; hw_store_n = 1'b1; arr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!nv_store && !nv_recall, "R1", nv_store, 0);
    check(!busy && !standby, "R1", busy, 0);
    check(bus_mode == 2'd0 && !dq_drive, "R1", bus_mode, 0);

    // R12 mode decode on live bus
    cur_req = "R12";
    @(negedge clk);
    mem_ce_n = 1'b0; mem_we_n = 1'b1; mem_oe_n = 1'b0; mem_addr = 15'h0123;
    #1 check(bus_mode == 2'd1, "R12", bus_mode, 1);
    check(dq_drive == 1'b1, "R12", dq_drive, 1);
    @(negedge clk); mem_we_n = 1'b0;
    #1 check(bus_mode == 2'd2, "R12", bus_mode, 2);
    check(dq_drive == 1'b0, "R12", dq_drive, 0);
    @(negedge clk); mem_ce_n = 1'b1; mem_we_n = 1'b1; mem_oe_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 software store
    cur_req = "R2";
    expect_pulse(KIND_STORE, "R2");
    unlock_seq(15'h0FC0, 15'h0000, 1'b0);
    queue_drained("R2");
    check(busy == 1'b1, "R2", busy, 1);
    check(bus_mode == 2'd3, "R12", bus_mode, 3);

    // R8 cycles ignored while busy; no data drive
    cur_req = "R8";
    unlock_seq(15'h0FC0, 15'h0000, 1'b0);
    check(busy == 1'b1, "R8", busy, 1);
    @(negedge clk); mem_ce_n = 1'b0; mem_oe_n = 1'b0;
    #1 check(dq_drive == 1'b0, "R8", dq_drive, 0);
    @(negedge clk); mem_ce_n = 1'b1; mem_oe_n = 1'b1;
    finish_op;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R2", busy, 0);

    // R10 hardware request with no write since last operation
    cur_req = "R10";
    @(negedge clk); hw_store_n = 1'b0;
    repeat (3) @(negedge clk);
    check(standby == 1'b1 && busy == 1'b0, "R10", standby, 1);
    @(negedge clk); hw_store_n = 1'b1;
    repeat (2) @(negedge clk);
    check(standby == 1'b0, "R10", standby, 0);

    // R9 hardware request after a write
    cur_req = "R9";
    bus_cycle(15'h0044, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    expect_pulse(KIND_STORE, "R9");
    hw_store_n = 1'b0;
    repeat (3) @(negedge clk);
    queue_drained("R9");
    check(busy == 1'b1, "R9", busy, 1);
    finish_op;
    check(busy == 1'b0 && standby == 1'b1, "R9", standby, 1);
    repeat (3) @(negedge clk);
    check(standby == 1'b1, "R9", standby, 1);
    hw_store_n = 1'b1;
    repeat (2) @(negedge clk);
    check(standby == 1'b0 && busy == 1'b0, "R9", standby, 0);

    // R3 + R7 recall with output enable held high
    cur_req = "R7";
    expect_pulse(KIND_RECALL, "R3/R7");
    unlock_seq(15'h0C63, 15'h0000, 1'b1);
    queue_drained("R7");
    check(busy == 1'b1, "R3", busy, 1);
    finish_op;

    // R11 write, recall, then hardware request issues nothing
    cur_req = "R11";
    bus_cycle(15'h0100, 1'b0, 1'b1);
    expect_pulse(KIND_RECALL, "R11");
    unlock_seq(15'h0C63, 15'h0000, 1'b0);
    finish_op;
    repeat (2) @(negedge clk);
    hw_store_n = 1'b0;
    repeat (3) @(negedge clk);
    queue_drained("R11");
    check(standby == 1'b1 && busy == 1'b0, "R11", busy, 0);
    hw_store_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 write in the middle breaks the sequence
    cur_req = "R4";
    bus_cycle(15'h0E38, 1'b1, 1'b0);
    bus_cycle(15'h31C7, 1'b1, 1'b0);
    bus_cycle(15'h03E0, 1'b0, 1'b1);
    bus_cycle(15'h3C1F, 1'b1, 1'b0);
    bus_cycle(15'h303F, 1'b1, 1'b0);
    bus_cycle(15'h0FC0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R4", busy, 0);

    // R5 top address bit ignored
    cur_req = "R5";
    expect_pulse(KIND_STORE, "R5");
    unlock_seq(15'h0FC0, 15'h4000, 1'b0);
    queue_drained("R5");
    check(busy == 1'b1, "R5", busy, 1);
    finish_op;

    // R6 stray mismatch resets; repeat of first entry restarts at one
    cur_req = "R6";
    bus_cycle(15'h0E38, 1'b1, 1'b0);
    bus_cycle(15'h31C7, 1'b1, 1'b0);
    bus_cycle(15'h1234, 1'b1, 1'b0);
    bus_cycle(15'h03E0, 1'b1, 1'b0);
    bus_cycle(15'h3C1F, 1'b1, 1'b0);
    bus_cycle(15'h303F, 1'b1, 1'b0);
    bus_cycle(15'h0FC0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R6", busy, 0);
    bus_cycle(15'h0E38, 1'b1, 1'b0);
    bus_cycle(15'h31C7, 1'b1, 1'b0);
    expect_pulse(KIND_RECALL, "R6");
    unlock_seq(15'h0C63, 15'h0000, 1'b0);
    queue_drained("R6");
    finish_op;

    repeat (4) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule